// File: doc/BRIEF.md
# Programmable Startup Phase Sequencer

This block runs the last stage of bringing a programmable device to life after its configuration data has loaded. A start pulse arms it. It then counts through eight numbered phases, 0 to 7, taking one step for each tick of a chosen stepping clock. It stops at phase 7 and raises a finished flag.

Four 3-bit run-time fields select when things happen. One selects the phase in which the global tristate on user I/Os is lifted. One selects the phase in which the global write enable turns on. One selects the phase in which the DONE signal is released. The fourth names a phase in which the count waits until a clock manager reports lock; the value 7 turns this wait off. The count also waits in the DONE phase until the DONE level fed back from the pad reads high. That feedback can pass through an optional register stage.

The stepping clock can come from three sources: the configuration clock, a user clock or the test clock. Each source reaches the block as a one-cycle tick strobe that is synchronous to the block clock. The selection is captured only while the sequencer is idle, so the source cannot change once a run has begun.

Top module: `sc_startup_seq`

## Requirements
- R1: During and after reset, and before any start, the outputs are: phase 0, finished low, gts_o high, gwe_o low, done_oe high and done_o low. This holds even when an event field is 0.
- R2: After start, each tick of the selected source moves the phase up by exactly one. The phase holds at 7. finished_o rises on the same edge on which the phase becomes 7.
- R3: gts_o goes low on the edge on which the phase becomes gts_ph (0 to 7) and stays low until reset. A field of 0 takes effect on the start edge.
- R4: gwe_o goes high on the edge on which the phase becomes gwe_ph and stays high until reset.
- R5: DONE is released on the edge on which the phase becomes done_ph (legal values 1 to 6). After release, done_drive=0 gives done_oe low (open drain) and done_drive=1 gives done_oe high with done_o high.
- R6: Events whose fields name the same phase all change on the same edge.
- R7: While the phase equals lock_ph and lock_in is low, ticks do not advance the phase. lock_ph=7 means no wait.
- R8: While the phase equals done_ph and the effective DONE feedback is low, ticks do not advance the phase.
- R9: With done_pipe=1, the DONE feedback passes through one register stage of the block clock before the stall logic uses it. With done_pipe=0 it is used directly.
- R10: clk_src 2'b00 selects tick_cfg, 2'b01 selects tick_user, and 2'b10 or 2'b11 selects tick_tck. Ticks from unselected sources have no effect.
- R11: clk_src is captured only while the sequencer is idle. A change after start does not change the stepping source.
- R12: Ticks before start have no effect. A start pulse during or after a run does not disturb the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low global reset |
| start | input | 1 | Start pulse that arms the sequencer |
| clk_src | input | 2 | Stepping source select |
| tick_cfg | input | 1 | Configuration-clock tick strobe |
| tick_user | input | 1 | User-clock tick strobe |
| tick_tck | input | 1 | Test-clock tick strobe |
| lock_in | input | 1 | Clock-manager lock |
| done_in | input | 1 | DONE level read back from the pad |
| done_pipe | input | 1 | Adds a register stage on done_in |
| done_drive | input | 1 | 1: drive DONE high after release; 0: open drain |
| done_ph | input | PH_W | Phase of DONE release |
| gts_ph | input | PH_W | Phase of the tristate release |
| gwe_ph | input | PH_W | Phase of the write-enable assertion |
| lock_ph | input | PH_W | Lock-wait phase (all ones = no wait) |
| done_o | output | 1 | DONE pad data |
| done_oe | output | 1 | DONE pad output enable |
| gts_o | output | 1 | Global tristate (1 = I/Os tristated) |
| gwe_o | output | 1 | Global write enable |
| phase_o | output | PH_W | Current phase |
| finished_o | output | 1 | Sequence complete |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is event outputs whose fields name one phase. Vectors set the tristate, write-enable and DONE fields equal, or one of them to 0, which makes it coincide with the start edge. After each tick the bench checks every output against the phase just reached. The second pair is a release of the DONE-feedback stall and a tick in the same cycle. done_in is raised on the very cycle a tick arrives, and the bench checks whether that tick advances the phase: it must with the pipeline stage off, and must not with the stage on.

// File: rtl/sc_pkg.sv
package sc_pkg;
    typedef enum logic [1:0] {
        SRC_CFG  = 2'b00,
        SRC_USER = 2'b01,
        SRC_TCK  = 2'b10
    } src_e;

    localparam int EV_GTS  = 0;
    localparam int EV_GWE  = 1;
    localparam int EV_DONE = 2;
    localparam int NUM_EV  = 3;
endpackage

// File: rtl/sc_step_sel.sv
module sc_step_sel (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle,
    input  logic [1:0] src_in,
    input  logic       tick_cfg,
    input  logic       tick_user,
    input  logic       tick_tck,
    output logic [1:0] src_q,
    output logic       step
);
    import sc_pkg::*;

    logic [1:0] src_d;

    always_comb begin
        src_d = src_q;
        if (idle) src_d = src_in;
        // high bit set picks the test clock regardless of the low bit
        if (src_q[1])                step = tick_tck;
        else if (src_q == SRC_USER)  step = tick_user;
        else                         step = tick_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= SRC_CFG;
        else        src_q <= src_d;
    end
endmodule

// File: rtl/sc_din_stage.sv
module sc_din_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic pipe_en,
    input  logic din,
    output logic dout
);
    logic din_d, din_q;

    always_comb begin
        din_d = din;
        dout  = pipe_en ? din_q : din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din_d;
    end
endmodule

// File: rtl/sc_evt_latch.sv
module sc_evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic fired_q
);
    logic fired_d;

    always_comb fired_d = fired_q | hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fired_q <= 1'b0;
        else        fired_q <= fired_d;
    end
endmodule

// File: rtl/sc_startup_seq.sv
module sc_startup_seq #(
    parameter int PH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      clk_src,
    input  logic            tick_cfg,
    input  logic            tick_user,
    input  logic            tick_tck,
    input  logic            lock_in,
    input  logic            done_in,
    input  logic            done_pipe,
    input  logic            done_drive,
    input  logic [PH_W-1:0] done_ph,
    input  logic [PH_W-1:0] gts_ph,
    input  logic [PH_W-1:0] gwe_ph,
    input  logic [PH_W-1:0] lock_ph,
    output logic            done_o,
    output logic            done_oe,
    output logic            gts_o,
    output logic            gwe_o,
    output logic [PH_W-1:0] phase_o,
    output logic            finished_o
);
    import sc_pkg::*;

    localparam logic [PH_W-1:0] LAST = '1;
    localparam logic [PH_W-1:0] PRE_LAST = LAST - 1'b1;

    typedef struct packed {
        logic            running;
        logic            fin;
        logic [PH_W-1:0] phase;
    } seq_t;

    seq_t st_d, st_q;

    logic              step, din_eff, lock_hold, done_hold, adv;
    logic [1:0]        src_q;
    logic              seq_run;
    logic [NUM_EV-1:0] hit, fired;
    logic [PH_W-1:0]   ev_ph [NUM_EV];

    sc_step_sel u_sel (
        .clk(clk), .rst_n(rst_n), .idle(!st_q.running), .src_in(clk_src),
        .tick_cfg(tick_cfg), .tick_user(tick_user), .tick_tck(tick_tck),
        .src_q(src_q), .step(step)
    );

    sc_din_stage u_din (
        .clk(clk), .rst_n(rst_n), .pipe_en(done_pipe), .din(done_in), .dout(din_eff)
    );

    always_comb begin
        st_d      = st_q;
        lock_hold = (st_q.phase == lock_ph) && (lock_ph != LAST) && !lock_in;
        done_hold = (st_q.phase == done_ph) && !din_eff;
        adv       = st_q.running && !st_q.fin && step && !lock_hold && !done_hold;
        if (start && !st_q.running) st_d.running = 1'b1;
        if (adv) begin
            st_d.phase = st_q.phase + 1'b1;
            if (st_q.phase == PRE_LAST) st_d.fin = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ev_ph[EV_GTS]  = gts_ph;
    assign ev_ph[EV_GWE]  = gwe_ph;
    assign ev_ph[EV_DONE] = done_ph;

    for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
        assign hit[e] = st_d.running && (st_d.phase == ev_ph[e]);
        sc_evt_latch u_ev (.clk(clk), .rst_n(rst_n), .hit(hit[e]), .fired_q(fired[e]));
    end

    assign seq_run    = st_q.running;
    assign phase_o    = st_q.phase;
    assign finished_o = st_q.fin;
    assign gts_o      = !fired[EV_GTS];
    assign gwe_o      = fired[EV_GWE];
    assign done_oe    = !fired[EV_DONE] || done_drive;
    assign done_o     = fired[EV_DONE] && done_drive;
endmodule

// File: rtl/sc_startup_seq_chk.sv
module sc_startup_seq_chk #(
    parameter int PH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            running,
    input logic [1:0]      src_q,
    input logic [PH_W-1:0] phase_o,
    input logic            finished_o,
    input logic            gts_o,
    input logic            gwe_o,
    input logic [PH_W-1:0] gwe_ph,
    input logic [PH_W-1:0] lock_ph,
    input logic            lock_in
);
    localparam logic [PH_W-1:0] LAST = '1;

    // R1
    idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (phase_o == '0) && gts_o && !gwe_o);

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_o == $past(phase_o)) || (phase_o == PH_W'($past(phase_o) + 1'b1)));

    // R2
    fin_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finished_o |-> (phase_o == LAST));

    // R3
    gts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gts_o |=> !gts_o);

    // R4
    gwe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gwe_o) |-> (phase_o == gwe_ph));

    // R7
    lock_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && (phase_o == lock_ph) && (lock_ph != LAST) && !lock_in |=> $stable(phase_o));

    // R11
    src_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(src_q));
endmodule

bind sc_startup_seq sc_startup_seq_chk #(.PH_W(PH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(seq_run), .src_q(src_q),
    .phase_o(phase_o), .finished_o(finished_o), .gts_o(gts_o), .gwe_o(gwe_o),
    .gwe_ph(gwe_ph), .lock_ph(lock_ph), .lock_in(lock_in)
);

// File: tb/sc_startup_seq_tb.sv
module sc_startup_seq_tb;
    logic clk = 1'b0;
    logic rst_n, start, tick_cfg, tick_user, tick_tck, lock_in, done_in, done_pipe, done_drive;
    logic [1:0] clk_src;
    logic [2:0] done_ph, gts_ph, gwe_ph, lock_ph;
    logic done_o, done_oe, gts_o, gwe_o, finished_o;
    logic [2:0] phase_o;
    int n_run = 0, n_fail = 0;
    bit finished_run = 1'b0;

    always #5 clk = ~clk;

    sc_startup_seq u_dut (.*);

    // {gts_ph, gwe_ph, done_ph, clk_src, done_drive, ticks to finish}
    localparam logic [15:0] VEC [6] = '{
        {3'd5, 3'd6, 3'd4, 2'b00, 1'b0, 4'd7},
        {3'd0, 3'd0, 3'd1, 2'b01, 1'b1, 4'd7},
        {3'd3, 3'd3, 3'd3, 2'b10, 1'b0, 4'd7},
        {3'd7, 3'd2, 3'd6, 2'b11, 1'b1, 4'd7},
        {3'd1, 3'd7, 3'd5, 2'b00, 1'b1, 4'd7},
        {3'd2, 3'd5, 3'd2, 2'b01, 1'b0, 4'd7}
    };

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 0; tick_cfg = 0; tick_user = 0; tick_tck = 0;
        lock_in = 0; done_in = 1; done_pipe = 0; done_drive = 0; clk_src = 2'b00;
        done_ph = 3'd4; gts_ph = 3'd5; gwe_ph = 3'd6; lock_ph = 3'd7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic tick(logic [1:0] s);
        case (s)
            2'b00:   tick_cfg  = 1'b1;
            2'b01:   tick_user = 1'b1;
            default: tick_tck  = 1'b1;
        endcase
        @(negedge clk);
        tick_cfg = 0; tick_user = 0; tick_tck = 0;
    endtask

    // compare all outputs against the phase just reached
    task automatic chk_outs(string req, int ph, bit run);
        bit rel;
        rel = run && (ph >= done_ph);
        check({req, " phase"}, phase_o, ph);
        check({req, " gts"},   gts_o,   !(run && ph >= gts_ph));
        check({req, " gwe"},   gwe_o,   run && ph >= gwe_ph);
        check({req, " done_oe"}, done_oe, !rel || done_drive);
        check({req, " done_o"},  done_o,  rel && done_drive);
        check({req, " finished"}, finished_o, ph == 7);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished_run) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        // R1 reset state with defaults
        do_reset();
        chk_outs("R1", 0, 0);

        // Vector walk: R2 R3 R4 R5 R6 R7 (lock_ph=7 with lock low => no wait) R10
        foreach (VEC[i]) begin
            do_reset();
            {gts_ph, gwe_ph, done_ph, clk_src, done_drive} = VEC[i][15:4];
            @(negedge clk);
            chk_outs("R1 idle with fields", 0, 0);
            pulse_start();
            chk_outs("R3 R6 start edge", 0, 1);
            for (int t = 1; t <= int'(VEC[i][3:0]); t++) begin
                tick(clk_src);
                chk_outs("R2 R3 R4 R5 R6 step", t, 1);
            end
            tick(clk_src);
            chk_outs("R2 hold at 7", 7, 1);
        end

        // R12 ticks before start, start during run
        do_reset();
        tick(2'b00);
        check("R12 tick before start", phase_o, 0);
        pulse_start();
        tick(2'b00); tick(2'b00);
        pulse_start();
        check("R12 restart ignored", phase_o, 2);

        // R7 lock wait in phase 3
        do_reset();
        lock_ph = 3'd3;
        pulse_start();
        repeat (3) tick(2'b00);
        tick(2'b00);
        check("R7 stalled on lock", phase_o, 3);
        lock_in = 1'b1;
        tick(2'b00);
        check("R7 lock released", phase_o, 4);

        // R8 R9 DONE feedback stall, direct path
        do_reset();
        done_in = 1'b0;
        pulse_start();
        repeat (4) tick(2'b00);
        tick(2'b00);
        check("R8 stalled on done_in", phase_o, 4);
        done_in = 1'b1; tick(2'b00);
        check("R9 direct path same-cycle release", phase_o, 5);

        // R9 with pipeline stage
        do_reset();
        done_in = 1'b0; done_pipe = 1'b1;
        pulse_start();
        repeat (4) tick(2'b00);
        done_in = 1'b1; tick(2'b00);
        check("R9 pipelined feedback one cycle late", phase_o, 4);
        tick(2'b00);
        check("R9 pipelined release", phase_o, 5);

        // R10 unselected sources ignored
        do_reset();
        clk_src = 2'b01; @(negedge clk);
        pulse_start();
        tick(2'b00); tick(2'b10);
        check("R10 unselected ignored", phase_o, 0);
        tick(2'b01);
        check("R10 user source steps", phase_o, 1);

        // R11 select frozen after start
        do_reset();
        pulse_start();
        clk_src = 2'b01;
        tick(2'b01);
        check("R11 new source ignored", phase_o, 0);
        tick(2'b00);
        check("R11 captured source steps", phase_o, 1);

        finished_run = 1'b1;
        summary();
    end
endmodule